// File: doc/BRIEF.md
# MASH Delta-Sigma Modulator

This block turns an unsigned fractional word into a stream of small signed integers whose long-run average equals that word divided by 2^N, with the quantisation error pushed towards high frequencies. It is the fractional control source for a fractional-N divider: each enabled cycle it emits an offset that is added to the integer division ratio.

Three error-feedback accumulators of N bits are cascaded. The first adds the input word; each later one adds the residue its predecessor produced in the same cycle. The carries are merged by a cancellation network into one output. Order 1, 2 or 3 is picked by a select input. A load strobe puts a seed into the first accumulator and clears everything else. When that seed is odd, the output period is fixed by the order and the input word, so spur positions are known at design time.

Top module: `mash_modulator`

## Requirements
- R1: Every accumulator forms sum = addend + state. Its carry is 1 exactly when the sum is 2^N or more, and its new state is the sum modulo 2^N.
- R2: Only the first accumulator adds `fracWord`. Accumulator k > 1 adds the residue that accumulator k-1 forms in the same cycle.
- R3: On an enabled cycle the next `yOut` is c1 + (c2 - c2') + (c3 - 2c3' + c3''). Here ' marks the value from the previous enabled cycle, and carries and delay terms of unused stages count as zero. `yOut` is registered and appears one cycle later, within -3..+4 for order 3, -1..+2 for order 2 and 0..1 for order 1.
- R4: A synchronous reset (`rst` high) clears all accumulators, delay terms and `yOut`, whatever the other inputs are.
- R5: When `loadStrobe` is high and `rst` is low, the first accumulator takes `seedWord` and all other state and `yOut` become zero. This takes priority over `sampleEn`.
- R6: With `rst`, `loadStrobe` and `sampleEn` all low, no state changes and `yOut` holds.
- R7: For order 3 with an odd seed, the state sequence repeats with period exactly 2^(N+1) for every input word.
- R8: For order 2 with an odd seed, the period is 2^(N+1) for an odd input, 2^N for an input that is a multiple of 4 (zero included), and 2^(N-1) for an input equal to two times an odd number.
- R9: For order 1, an input k1·2^k with k1 odd has period 2^N/2^k, and the zero input has period 1, for any seed.
- R10: `orderSel` = 1 selects order 1, 2 selects order 2, and 3 or 0 selects order 3. Stages above the chosen order stay at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| orderSel | input | 2 | Modulator order select |
| fracWord | input | WORD_W | Unsigned fractional input word |
| seedWord | input | WORD_W | Seed for the first accumulator |
| loadStrobe | input | 1 | Loads the seed and clears the other state |
| sampleEn | input | 1 | Advances the modulator by one sample |
| yOut | output | 4 | Signed modulator output |

## Verification
The assertions check on every cycle that reset and load leave a zero output, that an idle cycle leaves the output untouched, and that the output stays within the range set by the selected order. Exact sample values and the recurrence period are shown only by the bench. It sweeps every input word of a 6-bit instance at all three orders and with several seeds, compares each output with an arithmetic model, and compares the recurrence length with the closed-form period for each order and input.

// File: rtl/mash_pkg.sv
`timescale 1ns/1ps
package mash_pkg;
  // Number of cascaded accumulators in the widest configuration.
  localparam int MAX_STAGES = 3;
  // Output width: enough for the range -3..+4 of the third-order network.
  localparam int OUT_W = 4;

  // Strobes handed from the control to the datapath each cycle.
  typedef struct packed {
    logic                  clear;    // synchronous reset of every register
    logic                  seed;     // load seed into stage 1, clear the rest
    logic                  step;     // advance one sample
    logic [MAX_STAGES-1:0] stageOn;  // accumulators taking part in this order
  } mashCtrl_t;
endpackage

// File: rtl/mash_ctrl.sv
`timescale 1ns/1ps
module mash_ctrl
  import mash_pkg::*;
(
  input  logic      rst,
  input  logic      loadStrobe,
  input  logic      sampleEn,
  input  logic [1:0] orderSel,
  output mashCtrl_t ctrl
);
  logic [MAX_STAGES-1:0] orderMask;

  // Order decode: 1 -> one stage, 2 -> two stages, 3 or 0 -> all three.
  always_comb begin
    case (orderSel)
      2'd1:    orderMask = 3'b001;
      2'd2:    orderMask = 3'b011;
      default: orderMask = 3'b111;
    endcase
  end

  // Priority: reset, then seed load, then sample advance.
  always_comb begin
    ctrl.clear   = rst;
    ctrl.seed    = !rst && loadStrobe;
    ctrl.step    = !rst && !loadStrobe && sampleEn;
    ctrl.stageOn = orderMask;
  end
endmodule

// File: rtl/mash_accum.sv
`timescale 1ns/1ps
module mash_accum #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              init,
  input  logic [WORD_W-1:0] initVal,
  input  logic              step,
  input  logic              active,
  input  logic [WORD_W-1:0] addend,
  output logic              carry,
  output logic [WORD_W-1:0] residue
);
  logic [WORD_W-1:0] state;
  logic [WORD_W:0]   total;

  // One extra bit holds the overflow that becomes the quantiser output.
  assign total   = {1'b0, addend} + {1'b0, state};
  assign carry   = active & total[WORD_W];
  assign residue = total[WORD_W-1:0];

  always_ff @(posedge clk) begin
    if (init) begin
      state <= initVal;
    end else if (step) begin
      state <= active ? residue : '0;
    end
  end
endmodule

// File: rtl/mash_datapath.sv
`timescale 1ns/1ps
module mash_datapath
  import mash_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic                    clk,
  input  mashCtrl_t               ctrl,
  input  logic [WORD_W-1:0]       fracWord,
  input  logic [WORD_W-1:0]       seedWord,
  output logic signed [OUT_W-1:0] yOut
);
  logic [WORD_W-1:0]     stageFeed [MAX_STAGES];
  logic [WORD_W-1:0]     stageRes  [MAX_STAGES];
  logic [MAX_STAGES-1:0] stageCarry;

  // Accumulator chain: each stage after the first adds the residue the
  // previous stage forms in the same cycle.
  genvar k;
  generate
    for (k = 0; k < MAX_STAGES; k++) begin : g_stage
      logic [WORD_W-1:0] startVal;
      if (k == 0) begin : g_head
        assign stageFeed[k] = fracWord;
        assign startVal     = ctrl.seed ? seedWord : '0;
      end else begin : g_tail
        assign stageFeed[k] = stageRes[k-1];
        assign startVal     = '0;
      end
      mash_accum #(.WORD_W(WORD_W)) u_acc (
        .clk     (clk),
        .init    (ctrl.clear | ctrl.seed),
        .initVal (startVal),
        .step    (ctrl.step),
        .active  (ctrl.stageOn[k]),
        .addend  (stageFeed[k]),
        .carry   (stageCarry[k]),
        .residue (stageRes[k])
      );
    end
  endgenerate

  // Differentiator delay terms of the cancellation network.
  logic c2Dly, c3Dly, c3Dly2;
  logic signed [OUT_W-1:0] yNext;

  always_comb begin
    yNext = OUT_W'(stageCarry[0])
          + OUT_W'(stageCarry[1])
          - OUT_W'(c2Dly & ctrl.stageOn[1])
          + OUT_W'(stageCarry[2])
          - OUT_W'({c3Dly & ctrl.stageOn[2], 1'b0})
          + OUT_W'(c3Dly2 & ctrl.stageOn[2]);
  end

  always_ff @(posedge clk) begin
    if (ctrl.clear || ctrl.seed) begin
      c2Dly  <= 1'b0;
      c3Dly  <= 1'b0;
      c3Dly2 <= 1'b0;
      yOut   <= '0;
    end else if (ctrl.step) begin
      c2Dly  <= stageCarry[1];
      c3Dly  <= stageCarry[2];
      c3Dly2 <= c3Dly;
      yOut   <= yNext;
    end
  end
endmodule

// File: rtl/mash_modulator.sv
`timescale 1ns/1ps
module mash_modulator
  import mash_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [1:0]              orderSel,
  input  logic [WORD_W-1:0]       fracWord,
  input  logic [WORD_W-1:0]       seedWord,
  input  logic                    loadStrobe,
  input  logic                    sampleEn,
  output logic signed [OUT_W-1:0] yOut
);
  mashCtrl_t ctrl;

  mash_ctrl u_ctrl (
    .rst        (rst),
    .loadStrobe (loadStrobe),
    .sampleEn   (sampleEn),
    .orderSel   (orderSel),
    .ctrl       (ctrl)
  );

  mash_datapath #(.WORD_W(WORD_W)) u_dp (
    .clk      (clk),
    .ctrl     (ctrl),
    .fracWord (fracWord),
    .seedWord (seedWord),
    .yOut     (yOut)
  );
endmodule

// File: rtl/mash_modulator_chk.sv
`timescale 1ns/1ps
module mash_modulator_chk (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        orderSel,
  input logic              loadStrobe,
  input logic              sampleEn,
  input logic signed [3:0] yOut
);
  // R4: reset leaves a zero output
  a_r4_reset_zero: assert property (@(posedge clk)
    rst |=> (yOut == 4'sd0));

  // R5: seed load leaves a zero output, even with sampleEn high
  a_r5_load_zero: assert property (@(posedge clk) disable iff (rst)
    loadStrobe |=> (yOut == 4'sd0));

  // R6: idle cycle keeps the output
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!loadStrobe && !sampleEn) |=> $stable(yOut));

  // R3: overall output range
  a_r3_range_all: assert property (@(posedge clk) disable iff (rst)
    (yOut >= -4'sd3) && (yOut <= 4'sd4));

  // R3: first-order output range
  a_r3_range_ord1: assert property (@(posedge clk) disable iff (rst)
    (!loadStrobe && sampleEn && orderSel == 2'd1) |=> (yOut == 4'sd0 || yOut == 4'sd1));

  // R3: second-order output range
  a_r3_range_ord2: assert property (@(posedge clk) disable iff (rst)
    (!loadStrobe && sampleEn && orderSel == 2'd2) |=> (yOut >= -4'sd1 && yOut <= 4'sd2));
endmodule

bind mash_modulator mash_modulator_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .orderSel   (orderSel),
  .loadStrobe (loadStrobe),
  .sampleEn   (sampleEn),
  .yOut       (yOut)
);

// File: tb/test_mash_modulator.sv
`timescale 1ns/1ps
module test_mash_modulator;
  localparam int N = 6;
  localparam int M = 1 << N;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] orderSel = 2'd3;
  logic [N-1:0] fracWord = '0;
  logic [N-1:0] seedWord = '0;
  logic loadStrobe = 1'b0;
  logic sampleEn = 1'b0;
  logic signed [3:0] yOut;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  mash_modulator #(.WORD_W(N)) i_mash_modulator (
    .clk(clk), .rst(rst), .orderSel(orderSel), .fracWord(fracWord),
    .seedWord(seedWord), .loadStrobe(loadStrobe), .sampleEn(sampleEn), .yOut(yOut)
  );

  // Arithmetic model state
  int ms0, ms1, ms2, d2, d3, d33, yModel, curX, curOrd;

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic int ordEff(input int ord);
    return (ord == 0) ? 3 : ord;
  endfunction

  task automatic modelLoad(input int seed);
    ms0 = seed; ms1 = 0; ms2 = 0; d2 = 0; d3 = 0; d33 = 0; yModel = 0;
  endtask

  task automatic modelStep();
    int o, t0, t1, t2, c0, c1, c2, r0, r1, r2;
    o  = ordEff(curOrd);
    t0 = curX + ms0; c0 = t0 / M; r0 = t0 % M;
    t1 = r0 + ms1;   c1 = (o >= 2) ? t1 / M : 0; r1 = t1 % M;
    t2 = r1 + ms2;   c2 = (o >= 3) ? t2 / M : 0; r2 = t2 % M;
    yModel = c0 + c1 - ((o >= 2) ? d2 : 0) + c2 - 2 * ((o >= 3) ? d3 : 0) + ((o >= 3) ? d33 : 0);
    ms0 = r0; ms1 = (o >= 2) ? r1 : 0; ms2 = (o >= 3) ? r2 : 0;
    d33 = d3; d2 = c1; d3 = c2;
  endtask

  function automatic int modelPeriod(input int ord, input int x, input int seed);
    int o, a, b, c, t0, t1, t2;
    o = ordEff(ord);
    a = seed; b = 0; c = 0;
    for (int p = 1; p <= 8 * M; p++) begin
      t0 = x + a; a = t0 % M;
      t1 = a + b; b = (o >= 2) ? t1 % M : 0;
      t2 = b + c; c = (o >= 3) ? t2 % M : 0;
      if (a == seed && b == 0 && c == 0) return p;
    end
    return 0;
  endfunction

  function automatic int expPeriod(input int ord, input int x);
    int tz, o;
    o = ordEff(ord);
    tz = 0;
    if (x == 0) tz = N;
    else while (((x >> tz) & 1) == 0) tz++;
    if (o == 1) return M >> tz;
    if (o == 2) return (tz == 0) ? 2 * M : (tz >= 2) ? M : M / 2;
    return 2 * M;
  endfunction

  task automatic doLoad(input int ord, input int x, input int seed, input bit withEn);
    orderSel = 2'(ord); fracWord = N'(x); seedWord = N'(seed);
    curOrd = ord; curX = x;
    loadStrobe = 1'b1; sampleEn = withEn;
    @(posedge clk); #1;
    loadStrobe = 1'b0; sampleEn = 1'b0;
    modelLoad(seed);
    check("R5 load clears output", int'(yOut), 0);
  endtask

  task automatic doSteps(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      sampleEn = 1'b1;
      @(posedge clk); #1;
      modelStep();
      check(tag, int'(yOut), yModel);
    end
    sampleEn = 1'b0;
  endtask

  task automatic sweepCase(input int ord, input int x, input int seed, input string ptag);
    int p;
    p = modelPeriod(ord, x, seed);
    check(ptag, p, expPeriod(ord, x));
    doLoad(ord, x, seed, 1'b0);
    doSteps(p + 2, "R1 R2 R3 sample");
  endtask

  // Watchdog
  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R4 reset state", int'(yOut), 0);
    rst = 1'b0;

    // R1 R2: hand-computed first sample, x=63 seed=63 order 3:
    // 63+63=126 -> carry 1, residue 62; 62+0 -> no carry; 62+0 -> no carry; y=1
    doLoad(3, 63, 63, 1'b0);
    sampleEn = 1'b1; @(posedge clk); #1; sampleEn = 1'b0;
    check("R1 R2 first sample", int'(yOut), 1);

    // R7: order 3, every word, two odd seeds
    for (int x = 0; x < M; x++) begin
      sweepCase(3, x, 1, "R7 period order3");
      sweepCase(3, x, 37, "R7 period order3");
    end
    // R8: order 2, every word
    for (int x = 0; x < M; x++) sweepCase(2, x, 1, "R8 period order2");
    // R9: order 1, every word, odd and even seed
    for (int x = 0; x < M; x++) begin
      sweepCase(1, x, 1, "R9 period order1");
      sweepCase(1, x, 22, "R9 period order1");
    end
    // R10: code 0 behaves as order 3
    sweepCase(0, 11, 5, "R10 code0 period");
    doLoad(0, 44, 9, 1'b0);
    doSteps(40, "R10 code0 sample");

    // R6: idle cycles hold output and state
    doLoad(3, 19, 3, 1'b0);
    doSteps(20, "R6 before idle");
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #1;
      check("R6 idle hold", int'(yOut), yModel);
    end
    doSteps(20, "R6 after idle");

    // R5: load wins over sampleEn, sequence restarts from seed
    doLoad(3, 27, 7, 1'b1);
    doSteps(30, "R5 after load with enable");

    // R4: reset mid-run with sampleEn high clears all state
    sampleEn = 1'b1; rst = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0; sampleEn = 1'b0;
    check("R4 mid-run reset", int'(yOut), 0);
    modelLoad(0);
    doSteps(30, "R4 after reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule